// File: doc/BRIEF.md
# Ethernet Frame Buffer with Cut-Through Release and Pause Request

This block is a synchronous buffer for the 64-bit word stream of an Ethernet MAC. Each word carries a start-of-frame flag, an end-of-frame flag, a byte count for the last word, and an error flag. Words are kept in a 256-entry memory and leave in the order they arrived, with no change to any field. Frames are never filtered or altered.

The read side has two release policies, chosen by a section threshold. When the threshold is zero, a frame becomes readable only after its end word has been written (store-and-forward). When the threshold is nonzero, a frame also becomes readable once that many of its words are held (cut-through). A frame that ends before it reaches the threshold is released by its end word. Once a frame has begun to leave, it stays readable until its end word has gone out.

A second, independent threshold on the fill level raises a level-sensitive pause request. The request carries a programmed quanta value. It drops only after the fill level has fallen below the threshold minus a programmed hysteresis, and 16 words is the suggested hysteresis. The write side drops its ready while the memory is full. A write attempted while full is lost. It sets a sticky overflow flag and marks the end word of the truncated frame as errored.

Top module: `frame_fifo`

## Requirements
- R1: After reset, rd_valid, pause_req and overflow are 0, pause_quanta is 0 and wr_ready is 1.
- R2: Words are read in write order, with data, sof, eof, bcnt (0 to 7 meaning 1 to 8 valid bytes on the end word) and err returned unchanged. rd_valid is never 1 while the buffer is empty.
- R3: With cfg_section = 0, rd_valid stays 0 while the buffer holds only an incomplete frame. It becomes 1 in the cycle after that frame's eof word is accepted.
- R4: With cfg_section = N > 0, rd_valid becomes 1 in the cycle after the Nth word of the head frame is accepted, before its end word arrives.
- R5: With cfg_section = N > 0, a frame shorter than N words becomes readable in the cycle after its eof word is accepted.
- R6: Once the sof word of a frame has been read, rd_valid is 1 whenever the buffer is nonempty, until that frame's eof word is read. This holds even when fewer than cfg_section words are held.
- R7: wr_ready is 0 exactly while 256 words are held. A word presented while wr_ready is 0 is not stored.
- R8: A write presented while full sets overflow, which stays 1 until reset. The next accepted eof word is stored with err = 1.
- R9: In the cycle after the fill level is at or above cfg_pause_thr, pause_req is 1. pause_quanta equals cfg_quanta while pause_req is 1 and is 0 otherwise.
- R10: pause_req stays 1 while the fill level is at or above cfg_pause_thr - cfg_pause_hyst. It clears in the cycle after the level falls below that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Buffer can take a word |
| wr_data | input | 64 | Write data |
| wr_sof | input | 1 | Write word starts a frame |
| wr_eof | input | 1 | Write word ends a frame |
| wr_bcnt | input | 3 | Valid bytes minus one on the end word |
| wr_err | input | 1 | Frame error flag |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | 64 | Read data |
| rd_sof | output | 1 | Read word starts a frame |
| rd_eof | output | 1 | Read word ends a frame |
| rd_bcnt | output | 3 | Valid bytes minus one |
| rd_err | output | 1 | Frame error flag |
| cfg_section | input | 9 | Cut-through word threshold, 0 for store-and-forward |
| cfg_pause_thr | input | 9 | Fill level that raises the pause request |
| cfg_pause_hyst | input | 9 | Hysteresis below the threshold for release |
| cfg_quanta | input | 16 | Quanta value sent with the pause request |
| pause_req | output | 1 | Pause request, level-sensitive |
| pause_quanta | output | 16 | Quanta while requesting, else 0 |
| overflow | output | 1 | Sticky write-while-full flag |

## Verification
In store-and-forward mode, a complete frame is followed by an unfinished one. This separates gating on buffer occupancy from gating on completed frames. In cut-through mode, the bench brings a frame to exactly its section size, drains it below that size, and then refills it. This shows whether release is decided by the count alone or latched once reading starts. A two-word frame checks that a short frame is released by its end word. A full 256-word fill with a write attempt while full shows that the attempted word is dropped and that the error mark lands on the later end word. The pause test reads one word at a time through the hysteresis band and checks the cycle in which the request sets and the cycle in which it clears.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
    localparam int DATA_W = 64;
    localparam int BCNT_W = 3;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sof;
        logic              eof;
        logic [BCNT_W-1:0] bcnt;
        logic              err;
    } fword_t;

    function automatic logic at_or_above(input logic [15:0] level, input logic [15:0] thr);
        return level >= thr;
    endfunction
endpackage

// File: rtl/fbuf_store.sv
module fbuf_store
    import fbuf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  fword_t wword,
    input  logic   re,
    output fword_t rword
);
    fword_t mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (we) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (re) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[wp] <= wword;
    end

    assign rword = mem[rp];
endmodule

// File: rtl/fbuf_level.sv
module fbuf_level
    import fbuf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          re,
    input  logic [CW-1:0] thr,
    input  logic [CW-1:0] hyst,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          pause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (we && !re) begin
            level <= level + 1'b1;
        end else if (re && !we) begin
            level <= level - 1'b1;
        end
    end

    assign full  = (level == CW'(DEPTH));
    assign empty = (level == '0);

    // Release point compared with one extra bit so that hyst > thr is safe.
    logic [CW:0] lvl_plus_hyst;
    assign lvl_plus_hyst = {1'b0, level} + {1'b0, hyst};

    always_ff @(posedge clk) begin
        if (rst) begin
            pause <= 1'b0;
        end else if (at_or_above(16'(level), 16'(thr))) begin
            pause <= 1'b1;
        end else if (lvl_plus_hyst < {1'b0, thr}) begin
            pause <= 1'b0;
        end
    end
endmodule

// File: rtl/fbuf_release.sv
module fbuf_release
    import fbuf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_eof,
    input  logic          re,
    input  logic          re_sof,
    input  logic          re_eof,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] section,
    output logic          rd_ok
);
    logic [CW-1:0] done_frames;
    logic          mid_frame;
    logic          cut_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_frames <= '0;
        end else if (we_eof && !(re && re_eof)) begin
            done_frames <= done_frames + 1'b1;
        end else if (!we_eof && re && re_eof) begin
            done_frames <= done_frames - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_frame <= 1'b0;
        end else if (re && re_eof) begin
            mid_frame <= 1'b0;
        end else if (re && re_sof) begin
            mid_frame <= 1'b1;
        end
    end

    assign cut_ok = (section != '0) && (level >= section);
    assign rd_ok  = (done_frames != '0) || mid_frame || cut_ok;
endmodule

// File: rtl/frame_fifo.sv
module frame_fifo
    import fbuf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int QW    = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sof,
    input  logic              wr_eof,
    input  logic [BCNT_W-1:0] wr_bcnt,
    input  logic              wr_err,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sof,
    output logic              rd_eof,
    output logic [BCNT_W-1:0] rd_bcnt,
    output logic              rd_err,
    input  logic [CW-1:0]     cfg_section,
    input  logic [CW-1:0]     cfg_pause_thr,
    input  logic [CW-1:0]     cfg_pause_hyst,
    input  logic [QW-1:0]     cfg_quanta,
    output logic              pause_req,
    output logic [QW-1:0]     pause_quanta,
    output logic              overflow
);
    fword_t        wword, rword;
    logic          we, re, full, empty, rd_ok, trunc_mark;
    logic [CW-1:0] level;

    assign we       = wr_valid && !full;
    assign re       = rd_valid && rd_ready;
    assign wr_ready = !full;
    assign rd_valid = !empty && rd_ok;

    always_comb begin
        wword.data = wr_data;
        wword.sof  = wr_sof;
        wword.eof  = wr_eof;
        wword.bcnt = wr_bcnt;
        wword.err  = wr_err | (wr_eof & trunc_mark);
    end

    // A word lost while full leaves a truncated frame; flag its later end word.
    always_ff @(posedge clk) begin
        if (rst) begin
            overflow   <= 1'b0;
            trunc_mark <= 1'b0;
        end else begin
            if (wr_valid && full) begin
                overflow   <= 1'b1;
                trunc_mark <= 1'b1;
            end else if (we && wr_eof) begin
                trunc_mark <= 1'b0;
            end
        end
    end

    fbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .we(we), .wword(wword), .re(re), .rword(rword)
    );

    fbuf_level #(.DEPTH(DEPTH)) u_level (
        .clk(clk), .rst(rst), .we(we), .re(re),
        .thr(cfg_pause_thr), .hyst(cfg_pause_hyst),
        .level(level), .full(full), .empty(empty), .pause(pause_req)
    );

    fbuf_release #(.DEPTH(DEPTH)) u_release (
        .clk(clk), .rst(rst), .we_eof(we && wr_eof), .re(re),
        .re_sof(rword.sof), .re_eof(rword.eof),
        .level(level), .section(cfg_section), .rd_ok(rd_ok)
    );

    assign rd_data      = rword.data;
    assign rd_sof       = rword.sof;
    assign rd_eof       = rword.eof;
    assign rd_bcnt      = rword.bcnt;
    assign rd_err       = rword.err;
    assign pause_quanta = pause_req ? cfg_quanta : '0;
endmodule

// File: rtl/fbuf_checker.sv
module fbuf_checker #(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          wr_eof,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          rd_eof,
    input logic          rd_sof,
    input logic [CW-1:0] cfg_section,
    input logic [CW-1:0] cfg_pause_thr,
    input logic [CW-1:0] cfg_pause_hyst,
    input logic          pause_req,
    input logic          overflow
);
    logic [CW-1:0] occ, frames;
    logic          wacc, racc;

    assign wacc = wr_valid && wr_ready;
    assign racc = rd_valid && rd_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ    <= '0;
            frames <= '0;
        end else begin
            occ    <= occ + CW'(wacc) - CW'(racc);
            frames <= frames + CW'(wacc && wr_eof) - CW'(racc && rd_eof);
        end
    end

    assert_ready_full_R7: assert property (@(posedge clk) disable iff (rst)
        wr_ready == (occ != CW'(DEPTH)));

    assert_valid_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (occ != '0));

    assert_saf_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_section == '0 && rd_valid && rd_sof) |-> (frames != '0));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_pause_set_R9: assert property (@(posedge clk) disable iff (rst)
        (occ >= cfg_pause_thr) |=> pause_req);

    assert_pause_clr_R10: assert property (@(posedge clk) disable iff (rst)
        (({1'b0, occ} + {1'b0, cfg_pause_hyst}) < {1'b0, cfg_pause_thr}) |=> !pause_req);
endmodule

bind frame_fifo fbuf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_eof(wr_eof),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_eof(rd_eof), .rd_sof(rd_sof),
    .cfg_section(cfg_section), .cfg_pause_thr(cfg_pause_thr),
    .cfg_pause_hyst(cfg_pause_hyst), .pause_req(pause_req), .overflow(overflow)
);

// File: tb/frame_fifo_tb.sv
module frame_fifo_tb;
    import fbuf_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0, wr_err = 1'b0;
    logic [63:0] wr_data = '0;
    logic [2:0]  wr_bcnt = '0;
    logic        rd_ready = 1'b0;
    logic [8:0]  cfg_section = '0, cfg_pause_thr = 9'd300, cfg_pause_hyst = 9'd16;
    logic [15:0] cfg_quanta = 16'h7FFF;
    logic        wr_ready, rd_valid, rd_sof, rd_eof, rd_err, pause_req, overflow;
    logic [63:0] rd_data;
    logic [2:0]  rd_bcnt;
    logic [15:0] pause_quanta;

    int checks = 0;
    int errors = 0;
    fword_t exp_q[$];

    always #10 clk = ~clk;

    frame_fifo u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_bcnt(wr_bcnt),
        .wr_err(wr_err), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_bcnt(rd_bcnt), .rd_err(rd_err),
        .cfg_section(cfg_section), .cfg_pause_thr(cfg_pause_thr),
        .cfg_pause_hyst(cfg_pause_hyst), .cfg_quanta(cfg_quanta),
        .pause_req(pause_req), .pause_quanta(pause_quanta), .overflow(overflow)
    );

    task automatic check(input logic ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Drive one word for one cycle; the word is expected to be accepted.
    task automatic push(input logic [63:0] d, input logic s, input logic e,
                        input logic [2:0] b, input logic er, input logic exp_er);
        fword_t w;
        wr_valid = 1'b1; wr_data = d; wr_sof = s; wr_eof = e; wr_bcnt = b; wr_err = er;
        tick();
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0; wr_err = 1'b0;
        w.data = d; w.sof = s; w.eof = e; w.bcnt = b; w.err = exp_er;
        exp_q.push_back(w);
    endtask

    task automatic pop(input string req);
        fword_t e;
        int wait_n = 0;
        rd_ready = 1'b1;
        while (!rd_valid && wait_n < 50) begin
            tick();
            wait_n++;
        end
        e = exp_q.pop_front();
        check(rd_valid && rd_data == e.data && rd_sof == e.sof && rd_eof == e.eof &&
              rd_bcnt == e.bcnt && rd_err == e.err, req,
              {rd_valid, 9'd0, rd_data, rd_sof, rd_eof, rd_bcnt, rd_err},
              {1'b1, 9'd0, e.data, e.sof, e.eof, e.bcnt, e.err});
        tick();
        rd_ready = 1'b0;
    endtask

    task automatic t_reset();
        check(!rd_valid && wr_ready && !pause_req && !overflow && pause_quanta == 0, "R1",
              {rd_valid, wr_ready, pause_req, overflow, pause_quanta},
              {1'b0, 1'b1, 1'b0, 1'b0, 16'h0});
    endtask

    task automatic t_store_forward();
        cfg_section = '0;
        push(64'h0123_4567_89AB_CDEF, 1, 0, 0, 0, 0);
        check(!rd_valid, "R3 held before eof", rd_valid, 0);
        push(64'hFFFF_0000_FFFF_0000, 0, 0, 0, 0, 0);
        push(64'h0000_0000_0000_00A5, 0, 1, 3'd5, 0, 0);
        check(rd_valid, "R3 released after eof", rd_valid, 1);
        push(64'hAAAA_5555_AAAA_5555, 1, 0, 0, 1, 1);
        push(64'h8000_0000_0000_0001, 0, 0, 0, 1, 1);
        for (int i = 0; i < 3; i++) pop("R2 frame A");
        tick();
        check(!rd_valid, "R3 incomplete frame held", rd_valid, 0);
        push(64'h1357_9BDF_2468_ACE0, 0, 1, 3'd7, 1, 1);
        check(rd_valid, "R3 second frame released", rd_valid, 1);
        for (int i = 0; i < 3; i++) pop("R2 frame B with err");
    endtask

    task automatic t_cut_through();
        cfg_section = 9'd4;
        push(64'h10, 1, 0, 0, 0, 0);
        push(64'h11, 0, 0, 0, 0, 0);
        push(64'h12, 0, 0, 0, 0, 0);
        check(!rd_valid, "R4 below section", rd_valid, 0);
        push(64'h13, 0, 0, 0, 0, 0);
        check(rd_valid, "R4 section reached", rd_valid, 1);
        for (int i = 0; i < 3; i++) pop("R2 cut-through words");
        check(rd_valid, "R6 eligible below section", rd_valid, 1);
        pop("R2 cut-through word 3");
        check(!rd_valid, "R6 empty gives no valid", rd_valid, 0);
        push(64'h14, 0, 0, 0, 0, 0);
        check(rd_valid, "R6 eligible after refill", rd_valid, 1);
        push(64'h15, 0, 1, 3'd2, 0, 0);
        pop("R6 word 4");
        pop("R6 end word");
    endtask

    task automatic t_short_frame();
        cfg_section = 9'd4;
        push(64'h20, 1, 0, 0, 0, 0);
        check(!rd_valid, "R5 short frame held", rd_valid, 0);
        push(64'h21, 0, 1, 3'd0, 0, 0);
        check(rd_valid, "R5 short frame released", rd_valid, 1);
        pop("R5 word 0");
        pop("R5 word 1");
    endtask

    task automatic t_pause();
        cfg_section = '0; cfg_pause_thr = 9'd40; cfg_pause_hyst = 9'd16;
        for (int i = 0; i < 39; i++) push(64'(i + 100), i == 0, 0, 0, 0, 0);
        tick();
        check(!pause_req, "R9 below threshold", pause_req, 0);
        push(64'd139, 0, 1, 3'd1, 0, 0);
        tick();
        check(pause_req && pause_quanta == 16'h7FFF, "R9 asserted with quanta",
              {pause_req, pause_quanta}, {1'b1, 16'h7FFF});
        for (int i = 0; i < 16; i++) pop("R2 pause drain");
        tick();
        check(pause_req, "R10 held inside band", pause_req, 1);
        pop("R2 pause drain");
        tick();
        check(!pause_req && pause_quanta == 0, "R10 cleared below band",
              {pause_req, pause_quanta}, {1'b0, 16'h0});
        for (int i = 0; i < 23; i++) pop("R2 pause drain rest");
        cfg_pause_thr = 9'd300;
    endtask

    task automatic t_overflow();
        cfg_section = 9'd8;
        for (int i = 0; i < 256; i++) push(64'(i) ^ 64'hC0DE_0000_0000_0000, i == 0, 0, 0, 0, 0);
        check(!wr_ready, "R7 ready low when full", wr_ready, 0);
        wr_valid = 1'b1; wr_data = 64'hDEAD; wr_eof = 1'b1; wr_bcnt = 3'd4;
        tick();
        wr_valid = 1'b0; wr_eof = 1'b0;
        check(overflow, "R8 overflow set", overflow, 1);
        pop("R2 first word after full");
        check(wr_ready, "R7 ready after read", wr_ready, 1);
        push(64'hBEEF, 0, 1, 3'd6, 0, 1);
        for (int i = 0; i < 256; i++) pop("R8 truncated frame drain, end word err");
        check(!rd_valid, "R7 dropped word absent", rd_valid, 0);
        check(overflow, "R8 overflow sticky", overflow, 1);
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        t_reset();
        t_store_forward();
        t_cut_through();
        t_short_frame();
        t_pause();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule